// File: doc/BRIEF.md
# Supervisor Reset Pulse and Watchdog Generator

This block produces the two reset lines of a power supervisor. It collects three reset causes and stretches each into a reset pulse with a guaranteed minimum width. The causes are a filtered "supply below trip" flag, an external asynchronous reset request, and a watchdog timeout. The watchdog treats every level change on a chip-select line as a sign that the host is alive. Time is counted in ticks of a slow time base, which arrives as a one-cycle tick-enable. The comparator, the reference and the slow oscillator sit outside the block.

The supply flag is already synchronous. It must stay high for a number of consecutive system clocks before it counts as a cause, so short dips are rejected. Chip select and the external request are asynchronous, so each passes through a two-flop synchronizer before it is used. While any cause is present the reset is held. Once the last cause is gone, reset stays asserted for a fixed number of ticks. The watchdog count is held at zero while reset is asserted, and it starts again from zero when reset releases.

Top module: `supv_reset_gen`

## Requirements
- R1: The active-low output `rst_lo_n` is always the complement of the active-high output `rst_hi`. Each comes from its own register.
- R2: A clock edge with `rst_n` low asserts both outputs. Once `rst_n` goes high, with no other cause present, the outputs stay asserted for exactly PULSE_TICKS ticks. They release on the clock edge that consumes the last of those ticks.
- R3: An external request (`ext_rst_req`, active high, synchronized through two flops) of any length, even one clock, asserts reset. Reset is held while the request is present and for PULSE_TICKS ticks after it is removed.
- R4: When `supply_low` is high for GLITCH_CYC or more consecutive clocks, reset asserts. Reset is held while the flag stays high and for PULSE_TICKS ticks after it drops.
- R5: A `supply_low` pulse shorter than GLITCH_CYC consecutive clocks causes no reset. This also holds for several such pulses separated by a low clock.
- R6: Without chip-select transitions, reset fires again after WDOG_TICKS ticks have been consumed while reset was deasserted.
- R7: A rising edge and a falling edge of `cs_in` each restart the watchdog count from zero.
- R8: The watchdog count is held at zero while reset is asserted. After any reset pulse, including a long supply-low episode, the full WDOG_TICKS count is needed before the next watchdog reset.
- R9: A reset caused by the watchdog lasts exactly PULSE_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick | input | 1 | One-cycle enable from the slow time base |
| supply_low | input | 1 | Synchronous flag, high while the supply is below trip |
| ext_rst_req | input | 1 | Asynchronous external reset request, active high |
| cs_in | input | 1 | Asynchronous chip select, any edge feeds the watchdog |
| rst_hi | output | 1 | Active-high reset |
| rst_lo_n | output | 1 | Active-low reset |

## Verification
The pulse width is measured in consumed ticks after three kinds of release: leaving system reset, dropping one-clock and many-tick external requests, and dropping supply-low holds at and above the filter length. A wrong load value or a decrement that ignores the tick enable changes that tick count. Supply pulses one clock short of the filter, including pairs split by a single low clock, separate the consecutive-run filter from a plain accumulating one. Watchdog runs with no chip-select activity, and runs with toggles spaced at about 0.6 of the timeout, show whether one edge polarity is missed, whether the count is held during reset and whether it restarts after a pulse. A seeded random mix of these episodes repeats the measurements with varied lengths.

// File: rtl/supv_pkg.sv
// Shared types for the supervisor reset generator.
package supv_pkg;

    // Reset causes that the pulse stretcher merges.
    typedef struct packed {
        logic supply_low;
        logic ext_req;
        logic wdog_exp;
    } rst_cause_t;

    // True when any cause is active.
    function automatic logic any_cause(rst_cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/supv_sync2.sv
// Two-flop synchronizer, one chain per bit.
// Assumes: inputs are asynchronous levels; reset value is zero.
module supv_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic meta_q;
            logic sync_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                end else begin
                    meta_q <= d[gi];
                    sync_q <= meta_q;
                end
            end
            assign q[gi] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/supv_glitch_filt.sv
// Accepts a flag only after it has been high for GLITCH_CYC consecutive
// clocks. The output drops on the clock after the flag drops.
// Assumes: GLITCH_CYC >= 1 and a synchronous input.
module supv_glitch_filt #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [CW-1:0] run_q;

    // Count the consecutive high clocks and qualify the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            filt  <= 1'b0;
        end else if (!raw) begin
            run_q <= '0;
            filt  <= 1'b0;
        end else begin
            if (run_q != CW'(GLITCH_CYC))
                run_q <= run_q + 1'b1;
            filt <= (run_q >= CW'(GLITCH_CYC - 1));
        end
    end
endmodule

// File: rtl/supv_wdog.sv
// Watchdog: counts ticks while not held or kicked, and pulses expire for
// one clock when WDOG_TICKS ticks have elapsed.
// Assumes: WDOG_TICKS >= 2; hold and kick clear the count at once.
module supv_wdog #(
    parameter int WDOG_TICKS = 8000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic                               hold,
    input  logic                               kick,
    output logic                               expire,
    output logic [$clog2(WDOG_TICKS+1)-1:0]    cnt
);
    localparam int WW = $clog2(WDOG_TICKS + 1);
    localparam logic [WW-1:0] LAST = WW'(WDOG_TICKS - 1);

    // Advance the timeout count and flag its expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (hold || kick) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt    <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/supv_stretch.sv
// Pulse stretcher: reloads while a cause is active, counts down on ticks
// afterwards, and drives two separately registered reset outputs.
// Assumes: PULSE_TICKS >= 1; system reset leaves the outputs asserted.
module supv_stretch #(
    parameter int PULSE_TICKS = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic rst_hi,
    output logic rst_lo_n
);
    localparam int PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] FULL = PW'(PULSE_TICKS);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cnt_nxt;

    // Next count: reload on cause, step down on a tick.
    always_comb begin
        if (cause)
            cnt_nxt = FULL;
        else if (tick && (cnt_q != '0))
            cnt_nxt = cnt_q - 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    // Register the count and both output polarities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= FULL;
            rst_hi   <= 1'b1;
            rst_lo_n <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            rst_hi   <= (cnt_nxt != '0);
            rst_lo_n <= (cnt_nxt == '0);
        end
    end
endmodule

// File: rtl/supv_reset_gen.sv
// Supervisor reset generator top. It merges the filtered supply-low flag,
// the synchronized external request and the chip-select watchdog into one
// stretched reset pulse with both polarities.
// Assumes: tick is a one-clock strobe; supply_low is already synchronous.
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int PULSE_TICKS = 750,
    parameter int WDOG_TICKS  = 8000,
    parameter int GLITCH_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    input  logic ext_rst_req,
    input  logic cs_in,
    output logic rst_hi,
    output logic rst_lo_n
);
    localparam int WD_W = $clog2(WDOG_TICKS + 1);

    logic [1:0]      sync_out;
    logic            cs_s;
    logic            ext_s;
    logic            cs_d;
    logic            cs_edge;
    logic            low_filt;
    logic            wd_exp;
    logic [WD_W-1:0] wd_cnt;
    rst_cause_t      causes;

    supv_sync2 #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_in, ext_rst_req}),
        .q     (sync_out)
    );
    assign cs_s  = sync_out[1];
    assign ext_s = sync_out[0];

    // Delay chip select by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_d <= 1'b0;
        else        cs_d <= cs_s;
    end
    assign cs_edge = cs_s ^ cs_d;

    supv_glitch_filt #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (supply_low),
        .filt  (low_filt)
    );

    supv_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hold   (rst_hi),
        .kick   (cs_edge),
        .expire (wd_exp),
        .cnt    (wd_cnt)
    );

    // Collect the reset causes.
    always_comb begin
        causes.supply_low = low_filt;
        causes.ext_req    = ext_s;
        causes.wdog_exp   = wd_exp;
    end

    supv_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cause    (any_cause(causes)),
        .rst_hi   (rst_hi),
        .rst_lo_n (rst_lo_n)
    );
endmodule

// File: rtl/supv_reset_gen_chk.sv
// Checker for the supervisor reset generator, bound to the top module.
module supv_reset_gen_chk #(
    parameter int WDOG_TICKS = 8000
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 tick,
    input logic                                 rst_hi,
    input logic                                 rst_lo_n,
    input logic                                 ext_s,
    input logic                                 low_filt,
    input logic                                 wd_exp,
    input logic [$clog2(WDOG_TICKS+1)-1:0]      wd_cnt
);
    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lo_n != rst_hi);                                        // R1
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_hi) |-> $past(tick));                             // R2
    AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_s |=> rst_hi);                                          // R3
    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        low_filt |=> rst_hi);                                       // R4
    AST_WDOG_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |=> rst_hi);                                         // R6
    AST_WDOG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hi |=> (wd_cnt == '0));                                 // R8
    AST_EXPIRE_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |-> $past(!rst_hi));                                 // R8
endmodule

bind supv_reset_gen supv_reset_gen_chk #(.WDOG_TICKS(WDOG_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rst_hi   (rst_hi),
    .rst_lo_n (rst_lo_n),
    .ext_s    (ext_s),
    .low_filt (low_filt),
    .wd_exp   (wd_exp),
    .wd_cnt   (wd_cnt)
);

// File: tb/supv_reset_gen_test.sv
module supv_reset_gen_test;
    localparam int P    = 5;
    localparam int W    = 40;
    localparam int G    = 4;
    localparam int TDIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_low = 1'b0;
    logic ext_req = 1'b0;
    logic cs = 1'b0;
    logic rst_hi;
    logic rst_lo_n;

    int checks = 0;
    int errors = 0;
    int phase = 0;
    int comp_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supv_reset_gen #(.PULSE_TICKS(P), .WDOG_TICKS(W), .GLITCH_CYC(G)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .supply_low  (supply_low),
        .ext_rst_req (ext_req),
        .cs_in       (cs),
        .rst_hi      (rst_hi),
        .rst_lo_n    (rst_lo_n)
    );

    // Count the cycles in which the two outputs are not complements (R1).
    always @(negedge clk) if (rst_n && (rst_lo_n == rst_hi)) comp_bad++;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected pulse length in ticks for an episode kind; 3 is a glitch.
    function automatic int exp_pulse(int kind);
        return (kind == 3) ? 0 : P;
    endfunction

    // One clock: move to the negedge and set the tick for the next edge.
    task automatic cyc();
        @(negedge clk);
        phase = (phase + 1) % TDIV;
        tick  = (phase == 0);
    endtask

    // Return just after a tick has been consumed.
    task automatic after_tick();
        do cyc(); while (!tick);
        cyc();
    endtask

    // Ticks consumed while reset is asserted, until it releases.
    task automatic count_pulse(output int n);
        bit seen = 1'b0;
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            if (rst_hi) begin
                seen = 1'b1;
                if (tick) n++;
            end else if (seen) begin
                break;
            end
            cyc();
        end
    endtask

    // Ticks consumed while reset is deasserted, until it asserts.
    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            if (rst_hi) break;
            if (tick) n++;
            cyc();
        end
    endtask

    // Cycles with reset asserted over a fixed window.
    task automatic watch(input int ncyc, output int highs);
        highs = 0;
        for (int i = 0; i < ncyc; i++) begin
            cyc();
            if (rst_hi) highs++;
        end
    endtask

    task automatic toggle_cs();
        after_tick();
        cs = ~cs;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int h;
        int kind;
        int len;
        void'($urandom(32'd4242));

        // R2: reset state, then exactly P ticks after release.
        repeat (5) cyc();
        check(rst_hi == 1'b1 && rst_lo_n == 1'b0, "R2 reset state", rst_hi, 1);
        after_tick();
        rst_n = 1'b1;
        count_pulse(n);
        check(n == P, "R2 power-up pulse ticks", n, P);

        // R6: watchdog fires after W ticks; R9: its pulse is P ticks.
        count_low(n);
        check(n == W, "R6 watchdog ticks", n, W);
        count_pulse(n);
        check(n == P, "R9 watchdog pulse ticks", n, P);
        // R8: full count restarts after the watchdog pulse.
        count_low(n);
        check(n == W, "R8 restart after pulse", n, W);
        count_pulse(n);

        // R7: toggles spaced at 24 ticks keep reset off over 120 ticks.
        h = 0;
        toggle_cs();
        for (int k = 0; k < 5; k++) begin
            for (int t = 0; t < 24; t++) begin
                after_tick();
                if (rst_hi) h++;
            end
            cs = ~cs;
        end
        check(h == 0, "R7 both edges restart", h, 0);

        // R5: short supply pulses, including two split by one low clock.
        toggle_cs();
        supply_low = 1'b1;
        repeat (G - 1) cyc();
        supply_low = 1'b0;
        cyc();
        supply_low = 1'b1;
        repeat (G - 1) cyc();
        supply_low = 1'b0;
        watch(16, h);
        check(h == 0, "R5 split glitches ignored", h, 0);

        // R4 and R8: long supply-low hold beyond the watchdog timeout.
        toggle_cs();
        supply_low = 1'b1;
        repeat (W + 10) after_tick();
        check(rst_hi == 1'b1, "R4 held during supply low", rst_hi, 1);
        supply_low = 1'b0;
        count_pulse(n);
        check(n == P, "R4 pulse after supply recovery", n, P);
        count_low(n);
        check(n == W, "R8 watchdog cleared during long hold", n, W);
        count_pulse(n);

        // R3: one-clock external request gives a full pulse.
        toggle_cs();
        after_tick();
        ext_req = 1'b1;
        cyc();
        ext_req = 1'b0;
        count_pulse(n);
        check(n == P, "R3 one-clock request pulse", n, P);

        // Seeded random episodes.
        for (int e = 0; e < 16; e++) begin
            toggle_cs();
            kind = int'($urandom % 4);
            after_tick();
            case (kind)
                0: begin
                    len = 1 + int'($urandom % 3);
                    ext_req = 1'b1;
                    repeat (len) cyc();
                    ext_req = 1'b0;
                    count_pulse(n);
                    check(n == exp_pulse(kind), "R3 short request", n, exp_pulse(kind));
                end
                1: begin
                    len = 1 + int'($urandom % 6);
                    ext_req = 1'b1;
                    repeat (len) after_tick();
                    check(rst_hi == 1'b1, "R3 held during request", rst_hi, 1);
                    ext_req = 1'b0;
                    count_pulse(n);
                    check(n == exp_pulse(kind), "R3 long request", n, exp_pulse(kind));
                end
                2: begin
                    len = G + int'($urandom % 3);
                    supply_low = 1'b1;
                    repeat (len) cyc();
                    supply_low = 1'b0;
                    count_pulse(n);
                    check(n == exp_pulse(kind), "R4 qualified dip", n, exp_pulse(kind));
                end
                default: begin
                    len = 1 + int'($urandom % (G - 1));
                    supply_low = 1'b1;
                    repeat (len) cyc();
                    supply_low = 1'b0;
                    watch(16, h);
                    check(h == exp_pulse(kind), "R5 short dip ignored", h, exp_pulse(kind));
                end
            endcase
        end

        check(comp_bad == 0, "R1 outputs complementary", comp_bad, 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule